// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a single-port synchronous memory with a two-bit burst address counter, meant to sit behind a processor or cache controller as fast local storage. Every control input is sampled on the rising clock edge, with one exception: the output enable acts at once. Two address strobes can start an access. One belongs to the processor and can only start reads. The other belongs to the controller and can start reads or writes. Once a burst has started, an advance input either steps the counter to the next address of the burst or holds it on the current address. The counter steps in linear order or in interleaved order.

Three chip enables select the device. Writes are byte-lane granular, and a global write input can force all lanes to be written. The bidirectional data bus is modelled as separate write-data and read-data vectors plus a drive-enable, which is high exactly when the block would drive the bus. A static mode input chooses the read path. Flow-through mode presents read data in the cycle after the access edge. Registered mode adds one output register stage, and the drive-enable is delayed by the same stage.

Top module: `sburst_sram`

## Requirements
- R1: The block is selected only when `ce1_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0. A strobe cycle that is not selected is a deselect, and its output slot is not driven. After a deselect, a cycle with both strobes high stays deselected. `ce2_i` and `ce3_n_i` are ignored on cycles with no strobe.
- R2: A processor strobe (`adsp_n_i`=0) with `ce1_n_i`=1 is ignored. With `adsc_n_i`=1 that cycle acts as a continue or suspend cycle of the running burst, as `adv_n_i` selects.
- R3: A cycle started by the processor strobe (with `ce1_n_i`=0) is always a read of `addr_i`, whatever the write inputs are. Memory is left unchanged.
- R4: A cycle started by `adsc_n_i`=0, while the processor strobe is not taken, reads or writes `addr_i` according to the write decode of R5.
- R5: Write decode. `gw_n_i`=0 writes all lanes. Otherwise `bwe_n_i`=0 writes each lane i whose `byte_n_i[i]`=0, where lane i is data bits [i*LANE_W +: LANE_W]. Any other combination, including `bwe_n_i`=1 with byte enables low, is a read.
- R6: With both strobes high and `adv_n_i`=0, the cycle accesses the next burst address. Only the two low address bits change. In linear order (`lin_n_i`=0) they are start+n mod 4. In interleaved order (`lin_n_i`=1) they are start XOR n. The fifth access wraps to the start address.
- R7: With both strobes high and `adv_n_i`=1, the cycle accesses the current burst address again (suspend). Continue and suspend cycles read or write per R5.
- R8: With `ft_n_i`=0 (flow-through), a read sampled at edge k drives its data and `drv_en_o` between edge k and edge k+1. With `ft_n_i`=1 (registered), data and enable appear one cycle later, between edge k+1 and edge k+2.
- R9: The output slot of a write cycle is never driven, in either mode.
- R10: `oe_n_i`=1 forces `drv_en_o` low combinationally, in the same cycle. A read made with `oe_n_i`=1 still moves the burst counter (dummy read).
- R11: After reset the block is deselected and `drv_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | External address loaded by a strobe |
| adsp_n_i | input | 1 | Processor address strobe, active low |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce1_n_i | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_n_i | input | 1 | Chip enable 3, active low |
| gw_n_i | input | 1 | Global write of all lanes, active low |
| bwe_n_i | input | 1 | Byte write enable, active low |
| byte_n_i | input | LANES | Per-lane write select, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| ft_n_i | input | 1 | 0 = flow-through reads, 1 = registered reads |
| lin_n_i | input | 1 | 0 = linear burst order, 1 = interleaved |
| din_i | input | LANES*LANE_W | Write data of the current cycle |
| dout_o | output | LANES*LANE_W | Read data, zero when not driven |
| drv_en_o | output | 1 | Bus drive enable |

## Verification
In flow-through mode a read sampled at one rising edge is due after that edge. In registered mode it is due one edge later. An output-enable change shows within the same cycle, and a write cycle or deselect leaves its own output slot undriven. The bench changes inputs on the falling edge and reads outputs on the next falling edge. For registered mode it inserts one extra edge before the compare, so each check lands in the slot the requirement names. Output-enable checks sample one time unit after the input moves. Mode changes are surrounded by deselect cycles, so no slot straddles a mode switch.

// File: rtl/sbs_pkg.sv
// Package: shared types and burst ordering for the synchronous burst memory.
// Assumes a fixed two-bit burst counter, i.e. bursts of four accesses.
package sbs_pkg;

    localparam int BURST_W = 2;

    // Kind of cycle decoded from the strobes, enables and advance input.
    typedef enum logic [2:0] {
        CYC_DESEL    = 3'd0,
        CYC_BEGIN_RD = 3'd1,
        CYC_BEGIN_WR = 3'd2,
        CYC_CONT     = 3'd3,
        CYC_SUSP     = 3'd4
    } sbs_cyc_e;

    // Low address bits of burst step 'step' from start 'start'.
    function automatic logic [BURST_W-1:0] burst_slot(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input logic               linear
    );
        logic [BURST_W-1:0] sum;
        sum = start + step;
        return linear ? sum : (start ^ step);
    endfunction

endpackage

// File: rtl/sbs_cycle_decode.sv
// Module: sbs_cycle_decode
// Combinational decode of one bus cycle: deselect, begin read, begin write,
// continue or suspend. Also yields the per-lane write mask.
// Assumes: the processor strobe is masked by ce1_n; the second and third
// enables matter only on strobe cycles; a processor-started cycle never writes.
module sbs_cycle_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             adsp_n_i,
    input  logic             adsc_n_i,
    input  logic             adv_n_i,
    input  logic             ce1_n_i,
    input  logic             ce2_i,
    input  logic             ce3_n_i,
    input  logic             gw_n_i,
    input  logic             bwe_n_i,
    input  logic [LANES-1:0] byte_n_i,
    input  logic             active_i,
    output sbs_cyc_e         cyc_o,
    output logic [LANES-1:0] wr_mask_o,
    output logic             rd_fire_o
);

    logic             sel_full;
    logic             p_taken;
    logic [LANES-1:0] lane_req;
    logic             wr_any;
    logic             is_write;

    assign sel_full = !ce1_n_i && ce2_i && !ce3_n_i;
    assign p_taken  = !adsp_n_i && !ce1_n_i;

    // Per-lane write request: global write or selected byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_req
        assign lane_req[g] = !gw_n_i || (!bwe_n_i && !byte_n_i[g]);
    end

    assign wr_any = |lane_req;

    // Cycle classification with processor strobe taking priority.
    always_comb begin
        if (p_taken) begin
            cyc_o = sel_full ? CYC_BEGIN_RD : CYC_DESEL;
        end else if (!adsc_n_i) begin
            if (!sel_full)   cyc_o = CYC_DESEL;
            else if (wr_any) cyc_o = CYC_BEGIN_WR;
            else             cyc_o = CYC_BEGIN_RD;
        end else if (active_i) begin
            cyc_o = adv_n_i ? CYC_SUSP : CYC_CONT;
        end else begin
            cyc_o = CYC_DESEL;
        end
    end

    // Read/write direction of the decoded cycle.
    always_comb begin
        unique case (cyc_o)
            CYC_BEGIN_WR:       is_write = 1'b1;
            CYC_CONT, CYC_SUSP: is_write = wr_any;
            default:            is_write = 1'b0;
        endcase
    end

    assign wr_mask_o = is_write ? lane_req : '0;
    assign rd_fire_o = (cyc_o != CYC_DESEL) && !is_write;

endmodule

// File: rtl/sbs_burst_ctr.sv
// Module: sbs_burst_ctr
// Holds the burst base address and step count, and forms the address the
// current cycle accesses (combinationally, from this cycle's decode).
// Assumes ADDR_W > BURST_W; only the low BURST_W bits move within a burst.
module sbs_burst_ctr
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  sbs_cyc_e          cyc_i,
    input  logic              linear_i,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic              active_o
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               active_q;
    logic               begin_c;
    logic [ADDR_W-1:0]  eff_base;
    logic [BURST_W-1:0] eff_cnt;

    assign begin_c = (cyc_i == CYC_BEGIN_RD) || (cyc_i == CYC_BEGIN_WR);

    // Effective base and step for this cycle: load, advance or hold.
    always_comb begin
        eff_base = begin_c ? addr_i : base_q;
        if (begin_c)                eff_cnt = '0;
        else if (cyc_i == CYC_CONT) eff_cnt = cnt_q + 1'b1;
        else                        eff_cnt = cnt_q;
    end

    assign acc_addr_o = {eff_base[ADDR_W-1:BURST_W],
                         burst_slot(eff_base[BURST_W-1:0], eff_cnt, linear_i)};
    assign active_o   = active_q;

    // Burst state update; deselect ends the burst, a strobe begins one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (cyc_i == CYC_DESEL) begin
            active_q <= 1'b0;
        end else begin
            base_q   <= eff_base;
            cnt_q    <= eff_cnt;
            active_q <= 1'b1;
        end
    end

endmodule

// File: rtl/sbs_mem_array.sv
// Module: sbs_mem_array
// Storage split into byte lanes, each with its own write enable.
// Write is synchronous; read is combinational from a registered address.
// Assumes: storage cells are not reset; contents are defined only once written.
module sbs_mem_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_mask_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Lane write: store this lane's slice when its mask bit is set.
        always_ff @(posedge clk) begin
            if (wr_mask_i[g]) begin
                cells[wr_addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = cells[rd_addr_i];
    end

endmodule

// File: rtl/sbs_read_stage.sv
// Module: sbs_read_stage
// Captures the read address at the access edge, then selects flow-through or
// registered output. The drive enable follows the same delay as the data.
// Assumes ft_n_i is static while reads are in flight; oe_n_i only gates.
module sbs_read_stage #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              ft_n_i,
    input  logic              oe_n_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              drv_en_o
);

    logic [ADDR_W-1:0] ra_q;
    logic              rv_q;
    logic [DATA_W-1:0] pd_q;
    logic              pv_q;
    logic              sync_en;
    logic [DATA_W-1:0] stage_data;

    // Access register: address and valid of the read taken at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_q <= '0;
            rv_q <= 1'b0;
        end else begin
            rv_q <= rd_fire_i;
            if (rd_fire_i) ra_q <= acc_addr_i;
        end
    end

    // Output register: one-cycle copy of data and valid for registered mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q <= '0;
            pv_q <= 1'b0;
        end else begin
            pd_q <= mem_rdata_i;
            pv_q <= rv_q;
        end
    end

    assign rd_addr_o  = ra_q;
    assign sync_en    = ft_n_i ? pv_q : rv_q;
    assign stage_data = ft_n_i ? pd_q : mem_rdata_i;
    assign drv_en_o   = sync_en && !oe_n_i;
    assign dout_o     = drv_en_o ? stage_data : '0;

endmodule

// File: rtl/sburst_sram.sv
// Module: sburst_sram (top)
// Synchronous burst memory: cycle decode, burst counter, byte-lane storage
// and selectable read stage. The bidirectional bus is split into din_i,
// dout_o and drv_en_o. Write data is taken in the write cycle itself.
// Assumes ft_n_i and lin_n_i are mode straps, changed only while deselected.
module sburst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    adsp_n_i,
    input  logic                    adsc_n_i,
    input  logic                    adv_n_i,
    input  logic                    ce1_n_i,
    input  logic                    ce2_i,
    input  logic                    ce3_n_i,
    input  logic                    gw_n_i,
    input  logic                    bwe_n_i,
    input  logic [LANES-1:0]        byte_n_i,
    input  logic                    oe_n_i,
    input  logic                    ft_n_i,
    input  logic                    lin_n_i,
    input  logic [LANES*LANE_W-1:0] din_i,
    output logic [LANES*LANE_W-1:0] dout_o,
    output logic                    drv_en_o
);

    localparam int DATA_W = LANES * LANE_W;

    sbs_cyc_e          cyc;
    logic [LANES-1:0]  wr_mask;
    logic              rd_fire;
    logic              active;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] mem_rdata;

    sbs_cycle_decode #(.LANES(LANES)) u_decode (
        .adsp_n_i (adsp_n_i),
        .adsc_n_i (adsc_n_i),
        .adv_n_i  (adv_n_i),
        .ce1_n_i  (ce1_n_i),
        .ce2_i    (ce2_i),
        .ce3_n_i  (ce3_n_i),
        .gw_n_i   (gw_n_i),
        .bwe_n_i  (bwe_n_i),
        .byte_n_i (byte_n_i),
        .active_i (active),
        .cyc_o    (cyc),
        .wr_mask_o(wr_mask),
        .rd_fire_o(rd_fire)
    );

    sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .cyc_i     (cyc),
        .linear_i  (!lin_n_i),
        .acc_addr_o(acc_addr),
        .active_o  (active)
    );

    sbs_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk      (clk),
        .wr_mask_i(wr_mask),
        .wr_addr_i(acc_addr),
        .wdata_i  (din_i),
        .rd_addr_i(rd_addr),
        .rdata_o  (mem_rdata)
    );

    sbs_read_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_fire_i  (rd_fire),
        .acc_addr_i (acc_addr),
        .mem_rdata_i(mem_rdata),
        .ft_n_i     (ft_n_i),
        .oe_n_i     (oe_n_i),
        .rd_addr_o  (rd_addr),
        .dout_o     (dout_o),
        .drv_en_o   (drv_en_o)
    );

endmodule

// File: rtl/sbs_checker.sv
// Module: sbs_checker
// Port-level properties of sburst_sram, attached by bind below.
// Assumes ft_n_i changes only during runs of deselect cycles.
module sbs_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adsp_n_i,
    input logic             adsc_n_i,
    input logic             ce1_n_i,
    input logic             ce2_i,
    input logic             ce3_n_i,
    input logic             gw_n_i,
    input logic             bwe_n_i,
    input logic [LANES-1:0] byte_n_i,
    input logic             oe_n_i,
    input logic             ft_n_i,
    input logic             drv_en_o
);

    logic sel_full;
    logic p_taken;
    logic strobe_any;
    logic desel_strobe;
    logic wr_any;
    logic c_write;
    logic p_read;

    assign sel_full     = !ce1_n_i && ce2_i && !ce3_n_i;
    assign p_taken      = !adsp_n_i && !ce1_n_i;
    assign strobe_any   = p_taken || !adsc_n_i;
    assign desel_strobe = strobe_any && !sel_full;
    assign wr_any       = !gw_n_i || (!bwe_n_i && (|(~byte_n_i)));
    assign c_write      = !adsc_n_i && !p_taken && sel_full && wr_any;
    assign p_read       = p_taken && sel_full;

    // R1: a deselecting strobe leaves its flow-through slot undriven
    a_r1_desel_ft: assert property (@(posedge clk) disable iff (!rst_n)
        (desel_strobe && !ft_n_i) |=> !drv_en_o);

    // R1: a deselecting strobe leaves its registered slot undriven
    a_r1_desel_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        (desel_strobe && ft_n_i) |=> ##1 !drv_en_o);

    // R3: a processor-started cycle is a read even with write inputs active
    a_r3_adsp_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (p_read && !ft_n_i && !oe_n_i) |=> (drv_en_o || oe_n_i || ft_n_i));

    // R9: write cycle slot is never driven (flow-through)
    a_r9_write_quiet_ft: assert property (@(posedge clk) disable iff (!rst_n)
        (c_write && !ft_n_i) |=> !drv_en_o);

    // R9: write cycle slot is never driven (registered)
    a_r9_write_quiet_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        (c_write && ft_n_i) |=> ##1 !drv_en_o);

    // R10: output enable high always turns the drivers off
    a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !drv_en_o);

endmodule

bind sburst_sram sbs_checker #(.LANES(LANES)) u_sbs_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .adsp_n_i(adsp_n_i),
    .adsc_n_i(adsc_n_i),
    .ce1_n_i (ce1_n_i),
    .ce2_i   (ce2_i),
    .ce3_n_i (ce3_n_i),
    .gw_n_i  (gw_n_i),
    .bwe_n_i (bwe_n_i),
    .byte_n_i(byte_n_i),
    .oe_n_i  (oe_n_i),
    .ft_n_i  (ft_n_i),
    .drv_en_o(drv_en_o)
);

// File: tb/sburst_sram_tb_top.sv
// Directed bench for sburst_sram: one task per scenario, each self-checking.
// Inputs change on the falling edge; outputs are read on a falling edge.
module sburst_sram_tb_top;

    localparam int ADDR_W = 6;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr_i;
    logic              adsp_n_i, adsc_n_i, adv_n_i;
    logic              ce1_n_i, ce2_i, ce3_n_i;
    logic              gw_n_i, bwe_n_i;
    logic [LANES-1:0]  byte_n_i;
    logic              oe_n_i, ft_n_i, lin_n_i;
    logic [DW-1:0]     din_i;
    logic [DW-1:0]     dout_o;
    logic              drv_en_o;

    logic [DW-1:0] exp_mem [1 << ADDR_W];
    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    sburst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .adsp_n_i(adsp_n_i), .adsc_n_i(adsc_n_i), .adv_n_i(adv_n_i),
        .ce1_n_i(ce1_n_i), .ce2_i(ce2_i), .ce3_n_i(ce3_n_i),
        .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .byte_n_i(byte_n_i),
        .oe_n_i(oe_n_i), .ft_n_i(ft_n_i), .lin_n_i(lin_n_i),
        .din_i(din_i), .dout_o(dout_o), .drv_en_o(drv_en_o)
    );

    function automatic logic [DW-1:0] pat(input int a);
        logic [63:0] v;
        v = (64'(a) * 64'h0000_0001_0101_0101) ^ 64'h0000_000A_5C3E_96F1;
        return v[DW-1:0];
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    // One clock: edge samples inputs, return at following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Default inputs: a deselect cycle (controller strobe with ce1 high).
    task automatic idle_in();
        addr_i = '0; adsp_n_i = 1'b1; adsc_n_i = 1'b0; adv_n_i = 1'b1;
        ce1_n_i = 1'b1; ce2_i = 1'b1; ce3_n_i = 1'b0;
        gw_n_i = 1'b1; bwe_n_i = 1'b1; byte_n_i = '1;
        oe_n_i = 1'b0; din_i = '0;
    endtask

    task automatic desel(input int n);
        for (int i = 0; i < n; i++) begin
            idle_in();
            step();
        end
    endtask

    task automatic wr_full(input int a, input logic [DW-1:0] d);
        idle_in();
        ce1_n_i = 1'b0; addr_i = ADDR_W'(a); gw_n_i = 1'b0; din_i = d;
        step();
        exp_mem[a] = d;
    endtask

    task automatic rd_begin(input int a);
        idle_in();
        ce1_n_i = 1'b0; addr_i = ADDR_W'(a);
        step();
    endtask

    task automatic burst_next(input logic adv_n);
        idle_in();
        ce1_n_i = 1'b0; adsc_n_i = 1'b1; adv_n_i = adv_n;
        step();
    endtask

    task automatic expect_rd(input string tag, input int a);
        chk({tag, " drv_en"}, 64'(drv_en_o), 64'd1);
        chk({tag, " data"}, 64'(dout_o), 64'(exp_mem[a]));
    endtask

    task automatic expect_off(input string tag);
        chk({tag, " drv_en"}, 64'(drv_en_o), 64'd0);
    endtask

    task automatic t_reset();
        expect_off("R11 after reset");
        burst_next(1'b0);
        expect_off("R11 no burst after reset");
    endtask

    task automatic t_fill();
        for (int a = 0; a < 48; a++) wr_full(a, pat(a));
        expect_off("R9 write slot flow-through");
        rd_begin(17);
        expect_rd("R4 controller read", 17);
    endtask

    task automatic t_linear();
        lin_n_i = 1'b0;
        rd_begin(5);  expect_rd("R6 linear n0", 5);
        burst_next(1'b0); expect_rd("R6 linear n1", 6);
        burst_next(1'b0); expect_rd("R6 linear n2", 7);
        burst_next(1'b0); expect_rd("R6 linear n3", 4);
        burst_next(1'b0); expect_rd("R6 linear wrap", 5);
    endtask

    task automatic t_interleave();
        lin_n_i = 1'b1;
        rd_begin(10); expect_rd("R6 interleave n0", 10);
        burst_next(1'b0); expect_rd("R6 interleave n1", 11);
        burst_next(1'b0); expect_rd("R6 interleave n2", 8);
        burst_next(1'b0); expect_rd("R6 interleave n3", 9);
        burst_next(1'b0); expect_rd("R6 interleave wrap", 10);
        lin_n_i = 1'b0;
    endtask

    task automatic t_suspend();
        rd_begin(20);
        burst_next(1'b1); expect_rd("R7 suspend holds", 20);
        burst_next(1'b0); expect_rd("R7 continue after suspend", 21);
        // R7: write on a continue cycle goes to the next burst address
        idle_in(); ce1_n_i = 1'b0; adsc_n_i = 1'b1; adv_n_i = 1'b0;
        gw_n_i = 1'b0; din_i = pat(99); step();
        exp_mem[22] = pat(99);
        expect_off("R7 continue write slot");
        rd_begin(22); expect_rd("R7 continue write landed", 22);
    endtask

    task automatic t_bytes();
        logic [DW-1:0] nd;
        logic [DW-1:0] m;
        nd = ~pat(30);
        idle_in(); ce1_n_i = 1'b0; addr_i = 6'd30; bwe_n_i = 1'b0;
        byte_n_i = 4'b1010; din_i = nd; step();
        m = exp_mem[30];
        m[0*LANE_W +: LANE_W] = nd[0*LANE_W +: LANE_W];
        m[2*LANE_W +: LANE_W] = nd[2*LANE_W +: LANE_W];
        exp_mem[30] = m;
        rd_begin(30); expect_rd("R5 lanes 0 and 2 written", 30);
        idle_in(); ce1_n_i = 1'b0; addr_i = 6'd30; bwe_n_i = 1'b1;
        byte_n_i = 4'b0000; din_i = '0; step();
        expect_rd("R5 byte enables without bwe is a read", 30);
        idle_in(); ce1_n_i = 1'b0; addr_i = 6'd31; gw_n_i = 1'b0;
        bwe_n_i = 1'b1; byte_n_i = 4'b1111; din_i = nd; step();
        exp_mem[31] = nd;
        rd_begin(31); expect_rd("R5 global write all lanes", 31);
    endtask

    task automatic t_adsp_read();
        idle_in(); ce1_n_i = 1'b0; adsp_n_i = 1'b0; adsc_n_i = 1'b1;
        addr_i = 6'd33; gw_n_i = 1'b0; bwe_n_i = 1'b0; byte_n_i = '0;
        din_i = '0; step();
        expect_rd("R3 processor strobe reads", 33);
        rd_begin(33); expect_rd("R3 memory unchanged", 33);
    endtask

    task automatic t_adsp_blocked();
        rd_begin(40);
        idle_in(); ce1_n_i = 1'b1; adsp_n_i = 1'b0; adsc_n_i = 1'b1;
        adv_n_i = 1'b1; addr_i = 6'd12; step();
        expect_rd("R2 blocked strobe suspends", 40);
        idle_in(); ce1_n_i = 1'b1; adsp_n_i = 1'b0; adsc_n_i = 1'b1;
        adv_n_i = 1'b0; addr_i = 6'd12; step();
        expect_rd("R2 blocked strobe continues", 41);
    endtask

    task automatic t_select();
        idle_in(); ce1_n_i = 1'b0; ce2_i = 1'b0; addr_i = 6'd3; step();
        expect_off("R1 ce2 low deselects");
        idle_in(); ce1_n_i = 1'b0; adsp_n_i = 1'b0; adsc_n_i = 1'b1;
        ce3_n_i = 1'b1; addr_i = 6'd3; step();
        expect_off("R1 ce3 high deselects");
        burst_next(1'b0);
        expect_off("R1 stays deselected without strobe");
        rd_begin(44);
        idle_in(); ce1_n_i = 1'b0; adsc_n_i = 1'b1; adv_n_i = 1'b0;
        ce2_i = 1'b0; ce3_n_i = 1'b1; step();
        expect_rd("R1 ce2/ce3 ignored on continue", 45);
    endtask

    task automatic t_oe();
        idle_in(); ce1_n_i = 1'b0; addr_i = 6'd4; oe_n_i = 1'b1; step();
        expect_off("R10 oe high blocks drive");
        burst_next(1'b0);
        expect_rd("R10 dummy read advanced counter", 5);
        oe_n_i = 1'b1; #1;
        expect_off("R10 oe high same cycle");
        oe_n_i = 1'b0; #1;
        expect_rd("R10 oe low restores", 5);
    endtask

    task automatic t_pipe();
        desel(3);
        ft_n_i = 1'b1;
        desel(3);
        rd_begin(6);
        expect_off("R8 registered: nothing at access slot");
        wr_full(7, pat(77));
        expect_rd("R8 registered: data one cycle later", 6);
        idle_in(); step();
        expect_off("R9 write slot registered");
        rd_begin(8);
        burst_next(1'b0); expect_rd("R8 registered burst n0", 8);
        burst_next(1'b0); expect_rd("R8 registered burst n1", 9);
        idle_in(); step(); expect_rd("R8 registered burst n2", 10);
        idle_in(); step(); expect_off("R1 registered deselect slot");
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    // Main sequence.
    initial begin
        idle_in();
        ft_n_i = 1'b0;
        lin_n_i = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_linear();
        t_interleave();
        t_suspend();
        t_bytes();
        t_adsp_read();
        t_adsp_blocked();
        t_select();
        t_oe();
        t_pipe();
        report();
    end

endmodule